// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Evaluator

This block maps 12-bit pixel intensities through a tone curve built from 64 straight-line pieces. The pieces are narrow in the dark range and wide in the bright range. Every code from 0 to 15 has a piece to itself. Above that, each power-of-two octave up to 511 is cut into four equal pieces, and codes from 512 up are cut into pieces 128 codes wide. One curve serves the red, green and blue channels of a pixel alike.

Software loads the curve one word per piece through a simple write port. Each word holds an offset, which is the curve value at the first code of the piece, and a slope. The slope is a fixed-point number with 8 fraction bits: it is the rise across the piece times 256, divided by the piece width minus one. Writes land in a shadow copy of the table. A frame-start strobe then copies the whole shadow table into the active copy in one cycle, so a frame never sees a half-written table.

Pixels stream in and out with valid/ready handshakes through a two-stage pipeline. When the output is held off, both stages stall.

Top module: `gamma_pwl_eval`

## Requirements
- R1: The piece index of a code x is: x itself for x < 16. For 16 <= x < 512, with p the position of the leading one (4..8), it is 16 + 4*(p-4) + x[p-1:p-2]. For x >= 512 it is 32 + x[11:7]. The distance into the piece is x minus the first code of that piece.
- R2: A coefficient word carries the slope in bits [27:16] and the offset in bits [11:0]. Bits [31:28] and [15:12] are ignored.
- R3: Each output channel equals offset + ((slope * distance) >> 8), clamped to 4095, using the active entry of the piece that holds the input code.
- R4: The same active curve is applied to red, green and blue. Equal input codes give equal output codes.
- R5: A write with cfg_we high stores the word at entry cfg_addr of the shadow table and has no effect on outputs until frame_start. When frame_start is high at a clock edge, all 64 shadow entries become active at that edge.
- R6: After reset both tables hold the identity curve: slope 256 (unity) and offset equal to the piece's first code. Every output code then equals its input code.
- R7: After reset out_valid is 0 and in_ready is 1. A pixel accepted at one clock edge is presented on the output after the next edge when no back-pressure is applied. Pixels leave in the order they arrive.
- R8: While out_valid is high and out_ready is low, the output holds its value and in_ready is low.
- R9: When a write and frame_start fall in the same cycle, the active table takes the shadow contents from before that write. The written word becomes active at the following frame_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 6 | Coefficient entry (piece index) |
| cfg_wdata | input | 32 | Coefficient word |
| frame_start | input | 1 | Copy shadow table to active table |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 12 | Red input code |
| in_g | input | 12 | Green input code |
| in_b | input | 12 | Blue input code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_r | output | 12 | Red output code |
| out_g | output | 12 | Green output code |
| out_b | output | 12 | Blue output code |

## Verification
A pixel accepted at a clock edge shows up on the output after the next edge. The bench samples at the falling edge, so the first sample that can show the result is the falling edge after that second rising edge. The latency test probes both that falling edge and the one before it. The streaming tests do not count cycles. Instead they compare each output against a queue of expected values, and take a result off the queue only at a falling edge where out_valid and out_ready are both high, so stalls from random back-pressure cannot shift the comparison. A table swap takes effect at the frame_start edge itself. Pixels are sent only after that edge, and the bench's model of the active table is updated at the same point.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int PIX_W    = 12;
    localparam int NSEG     = 64;
    localparam int SEG_W    = $clog2(NSEG);
    localparam int WORD_W   = 32;
    localparam int FRAC_SH  = 8;
    localparam int NCH      = 3;
    localparam int FINE_N   = 16;             // single-code pieces
    localparam int OCT_LO   = 4;              // first octave bit
    localparam int OCT_HI   = 8;              // last octave bit
    localparam int COARSE_SH = 7;             // log2 of wide piece width
    localparam int DELTA_W  = COARSE_SH;
    localparam int OCT_BASE = FINE_N;
    localparam int COARSE_BASE = FINE_N + 4 * (OCT_HI - OCT_LO + 1);
    localparam int COARSE_START = 1 << (OCT_HI + 1);
    localparam int SAT_MAX  = (1 << PIX_W) - 1;
    localparam int SLOPE_LO = 16;
    localparam int UNITY    = 1 << FRAC_SH;

    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [SEG_W-1:0]   seg_t;
    typedef logic [DELTA_W-1:0] delta_t;

    typedef struct packed {
        pix_t slope;
        pix_t offset;
    } coef_t;

    typedef struct packed {
        seg_t   idx;
        delta_t delta;
    } loc_t;

    function automatic coef_t unpack_word(input logic [WORD_W-1:0] w);
        coef_t c;
        c.slope  = w[SLOPE_LO +: PIX_W];
        c.offset = w[PIX_W-1:0];
        return c;
    endfunction

    function automatic pix_t seg_start(input seg_t idx);
        int i, k, sec;
        i = int'(idx);
        if (i < FINE_N) begin
            return pix_t'(i);
        end else if (i < COARSE_BASE) begin
            k   = i - OCT_BASE;
            sec = k >> 2;
            return pix_t'((FINE_N << sec) + (k & 3) * (4 << sec));
        end
        return pix_t'(COARSE_START + (i - COARSE_BASE) * (1 << COARSE_SH));
    endfunction

endpackage

// File: rtl/gamma_seg_locate.sv
module gamma_seg_locate
    import gamma_pkg::*;
(
    input  pix_t x_i,
    output loc_t loc_o
);

    always_comb begin
        loc_o.idx   = seg_t'(x_i[3:0]);
        loc_o.delta = '0;
        for (int p = OCT_LO; p <= OCT_HI; p++) begin
            if (x_i[p]) begin
                loc_o.idx   = seg_t'(OCT_BASE + 4 * (p - OCT_LO) + int'(x_i[p-1 -: 2]));
                loc_o.delta = delta_t'(x_i & pix_t'((1 << (p - 2)) - 1));
            end
        end
        if (|x_i[PIX_W-1:OCT_HI+1]) begin
            loc_o.idx   = seg_t'(COARSE_BASE - 4 + int'(x_i[PIX_W-1:COARSE_SH]));
            loc_o.delta = x_i[COARSE_SH-1:0];
        end
    end

    // R1: located piece must enclose the code and the distance must match
    always_comb begin
        assert_seg_encloses_R1: assert (x_i >= seg_start(loc_o.idx) &&
            (int'(x_i) - int'(seg_start(loc_o.idx))) == int'(loc_o.delta));
        if (loc_o.idx != seg_t'(NSEG - 1)) begin
            assert_seg_below_next_R1: assert (x_i < seg_start(loc_o.idx + seg_t'(1)));
        end
    end

endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
    import gamma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  seg_t                    wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    swap,
    input  seg_t  [NCH-1:0]         rd_idx,
    output coef_t [NCH-1:0]         rd_coef
);

    coef_t [NSEG-1:0] shadow_q;
    coef_t [NSEG-1:0] active_q;

    logic unused_rsv;
    assign unused_rsv = ^{wr_data[WORD_W-1:SLOPE_LO+PIX_W], wr_data[SLOPE_LO-1:PIX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSEG; i++) begin
                shadow_q[i].slope  <= pix_t'(UNITY);
                shadow_q[i].offset <= seg_start(seg_t'(i));
                active_q[i].slope  <= pix_t'(UNITY);
                active_q[i].offset <= seg_start(seg_t'(i));
            end
        end else begin
            if (wr_en) begin
                shadow_q[wr_addr] <= unpack_word(wr_data);
            end
            if (swap) begin
                active_q <= shadow_q;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign rd_coef[c] = active_q[rd_idx[c]];
    end

    // R5 / R9: swap copies the pre-write shadow; nothing else moves the active table
    assert_swap_copies_R5: assert property (@(posedge clk) disable iff (rst)
        swap |=> (active_q == $past(shadow_q)));
    assert_active_held_R9: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(active_q));

endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
    import gamma_pkg::*;
(
    input  coef_t  coef_i,
    input  delta_t delta_i,
    output pix_t   y_o
);

    logic [PIX_W+DELTA_W-1:0] prod;
    logic [PIX_W:0]           sum;

    always_comb begin
        prod = coef_i.slope * delta_i;
        sum  = {1'b0, coef_i.offset} + (PIX_W+1)'(prod >> FRAC_SH);
        y_o  = (sum > (PIX_W+1)'(SAT_MAX)) ? pix_t'(SAT_MAX) : sum[PIX_W-1:0];
    end

    // R3: result never drops below the piece offset; zero distance gives the offset
    always_comb begin
        assert_not_below_offset_R3: assert (y_o >= coef_i.offset);
        if (delta_i == '0) begin
            assert_zero_dist_R3: assert (y_o == coef_i.offset);
        end
    end

endmodule

// File: rtl/gamma_pwl_eval.sv
module gamma_pwl_eval
    import gamma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        frame_start,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [11:0] in_r,
    input  logic [11:0] in_g,
    input  logic [11:0] in_b,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [11:0] out_r,
    output logic [11:0] out_g,
    output logic [11:0] out_b
);

    pix_t  [NCH-1:0] in_ch;
    loc_t  [NCH-1:0] loc_now;
    loc_t  [NCH-1:0] s1_loc;
    seg_t  [NCH-1:0] s1_idx;
    coef_t [NCH-1:0] s1_coef;
    pix_t  [NCH-1:0] s1_y;
    pix_t  [NCH-1:0] out_q;
    logic            s1_valid;
    logic            advance;

    assign in_ch   = {in_r, in_g, in_b};
    assign advance = !(out_valid && !out_ready);
    assign in_ready = advance;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gamma_seg_locate u_loc (
            .x_i   (in_ch[c]),
            .loc_o (loc_now[c])
        );
        assign s1_idx[c] = s1_loc[c].idx;
        gamma_interp u_interp (
            .coef_i  (s1_coef[c]),
            .delta_i (s1_loc[c].delta),
            .y_o     (s1_y[c])
        );
    end

    gamma_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (seg_t'(cfg_addr)),
        .wr_data (cfg_wdata),
        .swap    (frame_start),
        .rd_idx  (s1_idx),
        .rd_coef (s1_coef)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
            s1_loc    <= '0;
            out_q     <= '0;
        end else if (advance) begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
            if (in_valid) begin
                s1_loc <= loc_now;
            end
            if (s1_valid) begin
                out_q <= s1_y;
            end
        end
    end

    assign out_r = out_q[2];
    assign out_g = out_q[1];
    assign out_b = out_q[0];

    // R8: stalled output must hold
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_q)));
    // R7: accepted pixel enters stage one, and stage one moves to the output
    assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> s1_valid);
    assert_forward_R7: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && in_ready) |=> out_valid);

endmodule

// File: tb/gamma_pwl_eval_tb.sv
`timescale 1ns/1ps
module gamma_pwl_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        frame_start;
    logic        in_valid;
    logic        in_ready;
    logic [11:0] in_r, in_g, in_b;
    logic        out_valid;
    logic        out_ready;
    logic [11:0] out_r, out_g, out_b;

    always #10 clk = ~clk;

    gamma_pwl_eval dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int checks = 0;
    int fails  = 0;
    int bstart [64];
    int act_slope [64], act_off [64];
    int shd_slope [64], shd_off [64];
    logic [35:0] q_exp [$];
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int seg_of(input int x);
        int s = 0;
        for (int i = 0; i < 64; i++) if (bstart[i] <= x) s = i;
        return s;
    endfunction

    function automatic int model(input int x);
        int s = seg_of(x);
        int y = act_off[s] + ((act_slope[s] * (x - bstart[s])) >>> 8);
        return (y > 4095) ? 4095 : y;
    endfunction

    function automatic logic [35:0] pix_pat(input int pat, input int k);
        int r, g, b;
        case (pat)
            0: begin r = k; g = k; b = k; end
            1: begin r = k; g = 4095 - k; b = (k * 7 + 3) % 4096; end
            default: begin r = 0; g = 0; b = 0; end
        endcase
        return {12'(r), 12'(g), 12'(b)};
    endfunction

    task automatic write_coef(input int a, input int slope, input int off, input bit swap);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a);
        cfg_wdata = {4'hA, 12'(slope), 4'h5, 12'(off)};
        frame_start = swap;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
        if (swap) begin
            for (int i = 0; i < 64; i++) begin
                act_slope[i] = shd_slope[i]; act_off[i] = shd_off[i];
            end
        end
        shd_slope[a] = slope; shd_off[a] = off;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 64; i++) begin
            act_slope[i] = shd_slope[i]; act_off[i] = shd_off[i];
        end
    endtask

    task automatic stream(input int n, input int pat, input int stride, input bit bp, input string req);
        int sent = 0;
        int got = 0;
        logic [35:0] px, ex, ac;
        while (got < n) begin
            @(negedge clk);
            out_ready = bp ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (out_valid && out_ready) begin
                ex = q_exp.pop_front();
                ac = {out_r, out_g, out_b};
                check(ac == ex, req, int'(ac[35:24]), int'(ex[35:24]));
                got++;
            end
            if (sent < n) begin
                px = pix_pat(pat, (sent * stride) % 4096);
                in_valid = 1'b1;
                {in_r, in_g, in_b} = px;
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (in_valid && in_ready) begin
                q_exp.push_back({12'(model(int'(px[35:24]))),
                                 12'(model(int'(px[23:12]))),
                                 12'(model(int'(px[11:0])))});
                sent++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w, cur, a_val, b_val;
        for (int i = 0; i < 64; i++) begin
            w = (i < 16) ? 1 : (i < 36) ? (4 << ((i - 16) / 4)) : 128;
            bstart[i] = cur;
            cur += w;
            act_slope[i] = 256; act_off[i] = bstart[i];
            shd_slope[i] = 256; shd_off[i] = bstart[i];
        end
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frame_start = 0;
        in_valid = 0; in_r = 0; in_g = 0; in_b = 0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: reset state
        check(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);

        // R6: identity curve after reset, every code
        stream(4096, 0, 1, 1'b0, "R6 identity");

        // R2: load a curve with junk in the ignored bits; R5: not yet active
        for (int i = 0; i < 64; i++) begin
            if (i == 63) write_coef(i, 4095, 4090, 1'b0);
            else write_coef(i, (i * 523 + 77) % 4096, (i * 389 + 11) % 4096, 1'b0);
        end
        stream(256, 1, 16, 1'b1, "R5 before frame_start");

        // R1/R2/R3: after the swap, full sweep with back-pressure
        pulse_frame();
        stream(4096, 1, 1, 1'b1, "R1/R2/R3 curve");
        // R4: same code on all channels gives same output
        stream(512, 0, 8, 1'b1, "R4 shared curve");

        // R7: exact latency
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b1;
        {in_r, in_g, in_b} = pix_pat(0, 700);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R7 not early", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7 latency valid", int'(out_valid), 1);
        check(int'(out_r) == model(700), "R7 latency data", int'(out_r), model(700));
        @(negedge clk);
        check(out_valid == 1'b0, "R7 single beat", int'(out_valid), 0);

        // R8: back-pressure hold
        a_val = 1500; b_val = 3000;
        out_ready = 1'b0; in_valid = 1'b1;
        {in_r, in_g, in_b} = pix_pat(0, a_val);
        @(negedge clk);
        {in_r, in_g, in_b} = pix_pat(0, b_val);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(out_valid && int'(out_g) == model(a_val), "R8 hold data", int'(out_g), model(a_val));
            check(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid && int'(out_b) == model(b_val), "R8 release order", int'(out_b), model(b_val));
        @(negedge clk);
        check(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);

        // R9: write together with frame_start
        write_coef(0, 999, 777, 1'b1);
        stream(1, 2, 1, 1'b0, "R9 pre-write swap");
        check(model(0) != 777, "R9 model sanity", model(0), 11);
        pulse_frame();
        stream(1, 2, 1, 1'b0, "R9 next frame");
        check(model(0) == 777, "R9 model active", model(0), 777);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule